// File: doc/BRIEF.md
# Repartitionable Identifier Acceptance Filter

This block decides whether a received frame identifier is of interest to the local processor. It holds a 64-bit bank of code bits and a 64-bit bank of mask bits. Software writes both banks and a small control register through a byte-wide write port. The two banks can be read as two 32-bit filters, four 16-bit filters or eight 8-bit filters. Each filter has its own code and its own mask. A wider filter checks more identifier bits. A narrower filter layout gives more distinct filters.

The receive path presents a 32-bit packed identifier with a one-cycle valid strobe. A standard identifier fills the upper 11 bits. An extended identifier fills the upper 29 bits, base part first. One clock later the block reports three things: whether any active filter matched, the lowest-numbered matching filter, and a one-cycle interrupt pulse on acceptance. A frame that matches nothing produces a result with accept low and no interrupt.

The filter layout is protected by a configuration-enable bit. The layout can only be changed while that bit is already set. While the bit is set, every identifier is rejected.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, all outputs are low. The code bank is all zeros, the mask bank is all ones, the layout is two 32-bit filters and configuration-enable is clear. As a result, any identifier is accepted by filter 0.
- R2: Every cycle with `id_valid` high produces `hit_valid` high exactly one clock later. `hit_valid` is low in every other cycle.
- R3: A mask bit of 1 makes the corresponding identifier bit a don't-care. A mask bit of 0 requires the identifier bit to equal the corresponding code bit. A filter matches when all of its bits pass this test.
- R4: Write addresses 0 to 7 select code bytes and addresses 8 to 15 select mask bytes. In every layout, byte k of each bank holds the more significant bits of its filter's lower-numbered bytes. In layout 0 (two 32-bit filters), filter f uses bytes 4f..4f+3 and is compared with all 32 identifier bits. Byte 4f holds bits 31:24.
- R5: In layout 1 (four 16-bit filters), filter f uses bytes 2f (the upper byte) and 2f+1. It is compared with identifier bits 31:16.
- R6: In layout 2 (eight 8-bit filters), filter f uses byte f and is compared with identifier bits 31:24. Layout code 3 behaves as layout 2.
- R7: When several filters match, `hit_index` reports the lowest-numbered one.
- R8: When no filter matches, the result has `hit_accept` low, `hit_index` 0 and `irq` low.
- R9: While configuration-enable is set, every identifier is rejected.
- R10: The control register is at address 16. Bit 0 is configuration-enable and bits 2:1 are the layout code. A new layout code is taken only when configuration-enable was already set before the write. Otherwise the layout stays unchanged.
- R11: `irq` pulses for one cycle together with each result that has `hit_accept` high, and never at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address (0-7 code, 8-15 mask, 16 control) |
| cfg_wdata | input | 8 | Register write data |
| id_valid | input | 1 | Identifier valid strobe |
| id_in | input | 32 | Packed identifier, left-aligned |
| hit_valid | output | 1 | Result valid, one clock after `id_valid` |
| hit_accept | output | 1 | Some active filter matched |
| hit_index | output | 3 | Lowest-numbered matching filter |
| irq | output | 1 | Acceptance interrupt pulse |

## Verification
Every result is due exactly one clock after its strobe. Register writes take effect at the edge that samples them, so they affect the very next identifier. The driver changes inputs on falling edges and pushes the expected accept and index into a queue at the moment it raises the strobe. The monitor samples on the following falling edge, half a period after the registering edge. It pops one expected item per `hit_valid` and compares accept, index and `irq`. A result that arrives with no item queued, or a queue that is not empty at the end, counts as a failure.

// File: rtl/can_accept_filter.sv
module can_accept_filter #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              id_valid,
  input  logic [31:0]       id_in,
  output logic              hit_valid,
  output logic              hit_accept,
  output logic [2:0]        hit_index,
  output logic              irq
);

  localparam logic [1:0] L_W32 = 2'd0;
  localparam logic [1:0] L_W16 = 2'd1;
  localparam int         CTRL_ADDR = 16;

  logic [63:0] code_q, mask_q;
  logic        cfg_q;
  logic [1:0]  mode_q;
  logic [1:0]  hit32;
  logic [3:0]  hit16;
  logic [7:0]  hit8;
  logic [7:0]  hits;
  logic [2:0]  first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mask_q <= '1;
      cfg_q  <= 1'b0;
      mode_q <= L_W32;
    end else if (cfg_we) begin
      if (cfg_addr < ADDR_W'(8))
        code_q[63 - 8*cfg_addr[2:0] -: 8] <= cfg_wdata;
      else if (cfg_addr < ADDR_W'(16))
        mask_q[63 - 8*cfg_addr[2:0] -: 8] <= cfg_wdata;
      else if (cfg_addr == ADDR_W'(CTRL_ADDR)) begin
        cfg_q <= cfg_wdata[0];
        if (cfg_q) mode_q <= cfg_wdata[2:1];
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_w32
    assign hit32[g] = ~|((id_in ^ code_q[63-32*g -: 32]) & ~mask_q[63-32*g -: 32]);
  end
  for (genvar g = 0; g < 4; g++) begin : g_w16
    assign hit16[g] = ~|((id_in[31:16] ^ code_q[63-16*g -: 16]) & ~mask_q[63-16*g -: 16]);
  end
  for (genvar g = 0; g < 8; g++) begin : g_w8
    assign hit8[g] = ~|((id_in[31:24] ^ code_q[63-8*g -: 8]) & ~mask_q[63-8*g -: 8]);
  end

  assign hits = (mode_q == L_W32) ? {6'b0, hit32} :
                (mode_q == L_W16) ? {4'b0, hit16} : hit8;

  always_comb begin
    first = '0;
    for (int i = 7; i >= 0; i--)
      if (hits[i]) first = 3'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_valid  <= 1'b0;
      hit_accept <= 1'b0;
      hit_index  <= '0;
      irq        <= 1'b0;
    end else begin
      hit_valid  <= id_valid;
      hit_accept <= id_valid && !cfg_q && |hits;
      hit_index  <= (id_valid && !cfg_q) ? first : 3'd0;
      irq        <= id_valid && !cfg_q && |hits;
    end
  end

  // R2
  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> hit_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |=> !hit_valid);
  // R9
  a_r9_reject_in_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && cfg_q) |=> !hit_accept);
  // R10
  a_r10_layout_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q |=> $stable(mode_q));
  // R8
  a_r8_miss_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !hit_accept) |-> (hit_index == 3'd0 && !irq));
  // R11
  a_r11_irq_with_accept: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (hit_valid && hit_accept));
  // R4
  a_r4_index_range32: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_accept && $past(mode_q) == L_W32) |-> hit_index < 3'd2);

endmodule

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [4:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        id_valid = 0;
  logic [31:0] id_in = '0;
  logic        hit_valid, hit_accept, irq;
  logic [2:0]  hit_index;

  int checks = 0, fails = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  can_accept_filter u_dut (.*);

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 5'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input logic [31:0] id, input bit acc, input int idx, input string tag);
    @(negedge clk);
    id_in = id; id_valid = 1;
    exp_q.push_back({acc, 3'(idx)});
    tag_q.push_back(tag);
    @(negedge clk);
    id_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && hit_valid) begin
      if (exp_q.size() == 0)
        check(0, "R2 unexpected result", 1, 0);
      else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({hit_accept, hit_index} == e, t, {hit_accept, hit_index}, e);
        check(irq == e[3], {t, " R11 irq"}, irq, e[3]);
      end
    end
  end

  task automatic finish_run;
    check(exp_q.size() == 0, "R2 missing results", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    #1;
    check(!hit_valid && !hit_accept && !irq && hit_index == 0, "R1 reset outputs",
          {hit_valid, hit_accept, irq, hit_index}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    send(32'h1234_5678, 1, 0, "R1 reset accepts all at filter 0");

    // layout 0: f0 = AAAA_xxxx, f1 = 1234_xxxx
    wr(0, 'hAA); wr(1, 'hAA); wr(2, 0); wr(3, 0);
    wr(4, 'h12); wr(5, 'h34); wr(6, 0); wr(7, 0);
    wr(8, 0); wr(9, 0); wr(10, 'hFF); wr(11, 'hFF);
    wr(12, 0); wr(13, 0); wr(14, 'hFF); wr(15, 'hFF);
    send(32'hAAAA_1234, 1, 0, "R3 R4 filter0 32-bit");
    send(32'h1234_9999, 1, 1, "R4 filter1 32-bit");
    send(32'hAAAB_0000, 0, 0, "R8 miss 32-bit");

    wr(16, 'h02);
    send(32'h1234_9999, 1, 1, "R10 layout unchanged without enable");
    wr(16, 'h01);
    send(32'hAAAA_0000, 0, 0, "R9 reject while enabled");
    wr(16, 'h03); wr(16, 'h02);

    // layout 1: f0 AAAA, f1 5A5A, f2 1234, f3 12?4
    wr(2, 'h5A); wr(3, 'h5A); wr(10, 0); wr(11, 0);
    wr(6, 'h12); wr(7, 'h34); wr(14, 0); wr(15, 'hF0);
    send(32'hAAAA_FFFF, 1, 0, "R5 filter0 16-bit");
    send(32'h5A5A_0000, 1, 1, "R5 filter1 16-bit");
    send(32'h1234_0000, 1, 2, "R7 lowest of f2,f3 16-bit");
    send(32'h12F4_0000, 1, 3, "R3 R5 filter3 masked nibble");
    send(32'hAAAB_0000, 0, 0, "R8 miss 16-bit");

    wr(16, 'h05); wr(16, 'h04);
    send(32'hAA00_0000, 1, 0, "R7 lowest of f0,f1 8-bit");
    send(32'h5A00_0000, 1, 2, "R6 filter2 8-bit");
    send(32'h1200_0000, 1, 4, "R6 R7 filter4 8-bit");
    send(32'h3400_0000, 1, 5, "R6 R7 filter5 8-bit");
    send(32'h5400_0000, 1, 7, "R3 R6 filter7 masked nibble");
    send(32'h5500_0000, 0, 0, "R8 miss 8-bit");

    wr(16, 'h07); wr(16, 'h06);
    send(32'h5400_0000, 1, 7, "R6 layout code 3 as 8-bit");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule